// File: doc/BRIEF.md
# Debug Accumulator Access Sequencer

This block sits between a debug command port and the register files of a multiply-accumulate (MAC) unit and a floating-point unit. A debug read or write of a MAC accumulator returns or stores the exact bit contents only when the MAC status register has no rounding mode active. For that reason every accumulator request runs as a fixed chain of register operations. The chain first captures the live status value in a private holding register. It then writes zero to the status register, moves the accumulator data, and finally writes the held status value back. A write may also carry an extension-register value for the same accumulator. That write is issued right after the accumulator write, because writing an accumulator disturbs its extension register.

Other debug targets are single 32-bit operations with no guard chain. These are the extension registers, the status register itself, the two stack-pointer slots and the floating-point data registers. Each 64-bit floating-point register appears as two independent 32-bit halves. The block does not decide which stack-pointer slot is the user pointer and which is the supervisor pointer; the debug host resolves that from the processor's supervisor bit. A request is accepted when `req_valid` is high while `req_ready` is high. Completion is a one-cycle `rsp_done` pulse, with any read value on `rsp_rdata`.

Top module: `dbg_acc_seq`

## Requirements
- R1: An accumulator read (`req_sel` = 000nn, n the accumulator index) accepted at a clock edge drives four register operations in the next four cycles, one per cycle. They are: a read of the status register (address 0x00), a write of zero to address 0x00, a read of accumulator address 0x04+n, and a write to 0x00 of the value read in the first step.
- R2: An accumulator write uses the same chain, except that the third operation writes `req_wdata` to address 0x04+n.
- R3: On an accumulator write with `req_ext` high, one extra operation comes between the accumulator write and the restore. It writes `req_ext_data` to extension address 0x08+n. `req_ext` has no effect on reads or on any non-accumulator request.
- R4: The restore step writes the status value captured in the first step, even if the status register is changed by other logic while the chain runs.
- R5: `rsp_done` is high for exactly one cycle, the cycle after the last register operation of a request. `rsp_rdata` then shows the value read: the accumulator contents, not the status-register value. For writes and reserved codes it shows zero.
- R6: `req_ready` is low from the cycle after acceptance through the cycle of the last register operation, and high otherwise. A request presented while it is low causes no register operation.
- R7: Floating-point halves use `req_sel` = 1fffh. Upper half (h=1) maps to address 0x20+2f and lower half (h=0) to 0x21+2f. Each is one operation in the cycle after acceptance, with `rsp_done` the cycle after that, and the status register is not touched.
- R8: Direct single operations with the same timing as R7 apply to extension register n (`req_sel` 001nn, address 0x08+n), to stack-pointer slot x (`req_sel` 0100x, address 0x0C+x) and to the status register (`req_sel` 01010, address 0x00).
- R9: Reserved codes (01011 and 011xx) make no register operation. They raise `rsp_done` two cycles after acceptance with `rsp_rdata` zero.
- R10: During reset the block is idle: `req_ready` high, `reg_en` low, `rsp_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Debug request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_sel | input | 5 | Target register code |
| req_wdata | input | 32 | Write data for the target |
| req_ext | input | 1 | Accumulator write also updates its extension register |
| req_ext_data | input | 32 | Extension register write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| reg_en | output | 1 | Register port operation this cycle |
| reg_we | output | 1 | Register port write (1) or read (0) |
| reg_addr | output | 6 | Register port address |
| reg_wdata | output | 32 | Register port write data |
| reg_rdata | input | 32 | Register port read data, same cycle as the read |

## Verification
An accumulator request puts its operations in cycles 1 to 4 after the accepting edge, or cycles 1 to 5 when an extension write is included. Its done pulse comes in the cycle after that. A direct or reserved request has its single slot in cycle 1 and its done pulse in cycle 2. At acceptance the bench's reference model appends one expectation per future cycle to a queue. At every falling edge it removes exactly one entry and compares it with the register port, `req_ready`, `rsp_done` and `rsp_rdata`. An empty queue means an idle cycle is due. Status-register disturbance during a chain and requests raised while busy are injected in those same per-cycle slots.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAVE    = 3'd1,
    ST_CLEAR   = 3'd2,
    ST_XFER    = 3'd3,
    ST_EXT     = 3'd4,
    ST_RESTORE = 3'd5,
    ST_DIRECT  = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    CLS_ACC    = 2'd0,
    CLS_DIRECT = 2'd1,
    CLS_NONE   = 2'd2
  } sel_class_e;

  localparam int SEL_W = 5;

endpackage

// File: rtl/dbg_acc_rst_sync.sv
module dbg_acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dbg_acc_decode.sv
module dbg_acc_decode
  import dbg_acc_pkg::*;
#(
  parameter int AW        = 6,
  parameter int NUM_ACC   = 4,
  parameter int NUM_FP    = 8,
  parameter int STAT_ADDR = 0,
  parameter int ACC_BASE  = 4,
  parameter int EXT_BASE  = 8,
  parameter int SP_BASE   = 12,
  parameter int FP_BASE   = 32
) (
  input  logic [SEL_W-1:0] sel,
  output sel_class_e       cls,
  output logic [AW-1:0]    acc_addr,
  output logic [AW-1:0]    ext_addr,
  output logic [AW-1:0]    dir_addr
);
  logic acc_ok;
  logic fp_ok;

  // Index range checks: only elaborated when the count leaves codes unused
  generate
    if (NUM_ACC >= 4) begin : g_acc_full
      assign acc_ok = 1'b1;
    end else begin : g_acc_part
      assign acc_ok = (sel[1:0] < 2'(NUM_ACC));
    end
    if (NUM_FP >= 8) begin : g_fp_full
      assign fp_ok = 1'b1;
    end else begin : g_fp_part
      assign fp_ok = (sel[3:1] < 3'(NUM_FP));
    end
  endgenerate

  always_comb begin
    acc_addr = AW'(ACC_BASE) + AW'(sel[1:0]);
    ext_addr = AW'(EXT_BASE) + AW'(sel[1:0]);
    dir_addr = '0;
    cls      = CLS_NONE;
    if (sel[4]) begin
      // upper longword at the even slot, lower at the odd slot
      if (fp_ok) cls = CLS_DIRECT;
      dir_addr = AW'(FP_BASE) + AW'({sel[3:1], ~sel[0]});
    end else begin
      unique case (sel[3:2])
        2'b00: if (acc_ok) cls = CLS_ACC;
        2'b01: begin
          if (acc_ok) cls = CLS_DIRECT;
          dir_addr = ext_addr;
        end
        2'b10: begin
          if (!sel[1]) begin
            cls      = CLS_DIRECT;
            dir_addr = AW'(SP_BASE) + AW'(sel[0]);
          end else if (!sel[0]) begin
            cls      = CLS_DIRECT;
            dir_addr = AW'(STAT_ADDR);
          end
        end
        default: cls = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_acc_ctrl.sv
module dbg_acc_ctrl
  import dbg_acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       req_valid,
  input  sel_class_e req_cls,
  input  logic       req_write,
  input  logic       req_ext,
  output logic       req_ready,
  output logic       accept,
  output seq_state_e state_q,
  output logic       wr_q,
  output logic       ext_q,
  output logic       dir_ok_q
);
  seq_state_e state_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = (req_cls == CLS_ACC) ? ST_SAVE : ST_DIRECT;
      ST_SAVE:    state_d = ST_CLEAR;
      ST_CLEAR:   state_d = ST_XFER;
      ST_XFER:    state_d = (wr_q && ext_q) ? ST_EXT : ST_RESTORE;
      ST_EXT:     state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_IDLE;
      ST_DIRECT:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      ext_q    <= 1'b0;
      dir_ok_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wr_q     <= req_write;
        ext_q    <= req_ext && req_write && (req_cls == CLS_ACC);
        dir_ok_q <= (req_cls == CLS_DIRECT);
      end
    end
  end

  assert_clear_follows_save_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SAVE) |=> (state_q == ST_CLEAR));

  assert_ext_after_acc_write_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXT) |-> ($past(state_q) == ST_XFER) && wr_q);

  assert_ready_after_restore_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RESTORE) |=> req_ready);
endmodule

// File: rtl/dbg_acc_data.sv
module dbg_acc_data
  import dbg_acc_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              accept,
  input  seq_state_e        state_q,
  input  logic              wr_q,
  input  logic              dir_ok_q,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_ext_data,
  input  logic [AW-1:0]     acc_addr,
  input  logic [AW-1:0]     ext_addr,
  input  logic [AW-1:0]     dir_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_en,
  output logic              reg_we,
  output logic [AW-1:0]     reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] saved_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] wdata_q, ext_data_q;
  logic [AW-1:0]     acc_addr_q, ext_addr_q, dir_addr_q;
  logic              done_q, done_d;
  logic              save_en, rdata_en;

  // Register port slot for the current sequencer step
  always_comb begin
    reg_en    = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    unique case (state_q)
      ST_SAVE: begin
        reg_en   = 1'b1;
        reg_addr = AW'(STAT_ADDR);
      end
      ST_CLEAR: begin
        reg_en   = 1'b1;
        reg_we   = 1'b1;
        reg_addr = AW'(STAT_ADDR);
      end
      ST_XFER: begin
        reg_en    = 1'b1;
        reg_we    = wr_q;
        reg_addr  = acc_addr_q;
        reg_wdata = wdata_q;
      end
      ST_EXT: begin
        reg_en    = 1'b1;
        reg_we    = 1'b1;
        reg_addr  = ext_addr_q;
        reg_wdata = ext_data_q;
      end
      ST_RESTORE: begin
        reg_en    = 1'b1;
        reg_we    = 1'b1;
        reg_addr  = AW'(STAT_ADDR);
        reg_wdata = saved_q;
      end
      ST_DIRECT: begin
        reg_en    = dir_ok_q;
        reg_we    = wr_q;
        reg_addr  = dir_addr_q;
        reg_wdata = wdata_q;
      end
      default: reg_en = 1'b0;
    endcase
  end

  assign save_en  = (state_q == ST_SAVE);
  assign rdata_en = accept
                 || ((state_q == ST_XFER) && !wr_q)
                 || ((state_q == ST_DIRECT) && !wr_q && dir_ok_q);
  assign rdata_d  = accept ? '0 : reg_rdata;
  assign done_d   = (state_q == ST_RESTORE) || (state_q == ST_DIRECT);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_q    <= '0;
      rdata_q    <= '0;
      wdata_q    <= '0;
      ext_data_q <= '0;
      acc_addr_q <= '0;
      ext_addr_q <= '0;
      dir_addr_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= done_d;
      if (save_en)  saved_q <= reg_rdata;
      if (rdata_en) rdata_q <= rdata_d;
      if (accept) begin
        wdata_q    <= req_wdata;
        ext_data_q <= req_ext_data;
        acc_addr_q <= acc_addr;
        ext_addr_q <= ext_addr;
        dir_addr_q <= dir_addr;
      end
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  assert_saved_stable_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_SAVE) |=> $stable(saved_q));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_done |=> !rsp_done);
endmodule

// File: rtl/dbg_acc_seq.sv
module dbg_acc_seq
  import dbg_acc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AW        = 6,
  parameter int NUM_ACC   = 4,
  parameter int NUM_FP    = 8,
  parameter int STAT_ADDR = 0,
  parameter int ACC_BASE  = 4,
  parameter int EXT_BASE  = 8,
  parameter int SP_BASE   = 12,
  parameter int FP_BASE   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_ext,
  input  logic [DATA_W-1:0] req_ext_data,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              reg_en,
  output logic              reg_we,
  output logic [AW-1:0]     reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic          rst_ni;
  sel_class_e    cls;
  logic [AW-1:0] acc_addr, ext_addr, dir_addr;
  logic          accept, wr_q, ext_q, dir_ok_q;
  seq_state_e    state_q;

  dbg_acc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  dbg_acc_decode #(
    .AW(AW), .NUM_ACC(NUM_ACC), .NUM_FP(NUM_FP), .STAT_ADDR(STAT_ADDR),
    .ACC_BASE(ACC_BASE), .EXT_BASE(EXT_BASE), .SP_BASE(SP_BASE), .FP_BASE(FP_BASE)
  ) u_dec (
    .sel      (req_sel),
    .cls      (cls),
    .acc_addr (acc_addr),
    .ext_addr (ext_addr),
    .dir_addr (dir_addr)
  );

  dbg_acc_ctrl u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .req_valid (req_valid),
    .req_cls   (cls),
    .req_write (req_write),
    .req_ext   (req_ext),
    .req_ready (req_ready),
    .accept    (accept),
    .state_q   (state_q),
    .wr_q      (wr_q),
    .ext_q     (ext_q),
    .dir_ok_q  (dir_ok_q)
  );

  dbg_acc_data #(
    .AW(AW), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)
  ) u_data (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .accept       (accept),
    .state_q      (state_q),
    .wr_q         (wr_q),
    .dir_ok_q     (dir_ok_q),
    .req_wdata    (req_wdata),
    .req_ext_data (req_ext_data),
    .acc_addr     (acc_addr),
    .ext_addr     (ext_addr),
    .dir_addr     (dir_addr),
    .reg_rdata    (reg_rdata),
    .reg_en       (reg_en),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .rsp_done     (rsp_done),
    .rsp_rdata    (rsp_rdata)
  );
endmodule

// File: tb/sim_dbg_acc_seq.sv
`timescale 1ns/1ps
module sim_dbg_acc_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_ext;
  logic [4:0]  req_sel;
  logic [31:0] req_wdata, req_ext_data;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        reg_en, reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  dbg_acc_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .req_ext(req_ext), .req_ext_data(req_ext_data), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct {
    bit          is_done;
    bit          en;
    bit          we;
    int          addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  typedef struct {
    logic [4:0]  sel;
    bit          wr;
    bit          ext;
    logic [31:0] wd;
    logic [31:0] xd;
    bit          perturb;
    bit          pester;
    string       tag;
  } stim_t;

  logic [31:0] mem [64];
  exp_t  q[$];
  stim_t sq[$];
  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  int    idle_run = 0;
  bit    started = 0, finished = 0, perturb_arm = 0, pester_arm = 0;

  assign reg_rdata = mem[reg_addr];

  // Behavioural register file; optional disturbance of the status word
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h1000_0000 + 32'h0101_0101 * i;
      mem[0] <= 32'h0000_0030;
    end else begin
      if (reg_en && reg_we) mem[reg_addr] <= reg_wdata;
      if (perturb_arm && reg_en && reg_we && reg_addr == 6'd0 && reg_wdata == 32'd0)
        mem[0] <= 32'hDEAD_0001;
    end
  end

  function automatic exp_t mk(bit d, bit en, bit we, int a, logic [31:0] v, string t);
    exp_t e;
    e.is_done = d; e.en = en; e.we = we; e.addr = a; e.data = v; e.tag = t;
    return e;
  endfunction

  // Expected per-cycle activity for an accepted request, from the requirements
  task automatic plan(stim_t s);
    int a;
    bit valid;
    valid = 1;
    a = 0;
    if (!s.sel[4] && s.sel[3:2] == 2'b00) begin
      int n;
      logic [31:0] saved;
      n = int'(s.sel[1:0]);
      saved = mem[0];
      q.push_back(mk(0, 1, 0, 0, 0, s.tag));
      q.push_back(mk(0, 1, 1, 0, 0, s.tag));
      if (s.wr) q.push_back(mk(0, 1, 1, 4 + n, s.wd, s.tag));
      else      q.push_back(mk(0, 1, 0, 4 + n, 0, s.tag));
      if (s.wr && s.ext) q.push_back(mk(0, 1, 1, 8 + n, s.xd, s.tag));
      q.push_back(mk(0, 1, 1, 0, saved, s.tag));
      q.push_back(mk(1, 0, 0, 0, s.wr ? 32'd0 : mem[4 + n], s.tag));
      return;
    end
    if (s.sel[4]) a = 32 + 2 * int'(s.sel[3:1]) + (s.sel[0] ? 0 : 1);
    else if (s.sel[3:2] == 2'b01) a = 8 + int'(s.sel[1:0]);
    else if (s.sel[3:1] == 3'b100) a = 12 + int'(s.sel[0]);
    else if (s.sel[3:0] == 4'b1010) a = 0;
    else valid = 0;
    if (valid) begin
      q.push_back(mk(0, 1, s.wr, a, s.wd, s.tag));
      q.push_back(mk(1, 0, 0, 0, s.wr ? 32'd0 : mem[a], s.tag));
    end else begin
      q.push_back(mk(0, 0, 0, 0, 0, s.tag));
      q.push_back(mk(1, 0, 0, 0, 0, s.tag));
    end
  endtask

  task automatic add(logic [4:0] sel, bit wr, bit ext, logic [31:0] wd, logic [31:0] xd,
                     bit perturb, bit pester, string tag);
    stim_t s;
    s.sel = sel; s.wr = wr; s.ext = ext; s.wd = wd; s.xd = xd;
    s.perturb = perturb; s.pester = pester; s.tag = tag;
    sq.push_back(s);
  endtask

  // Per-cycle comparison and stimulus, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit   idle, ok;
      exp_t e;
      cyc++;
      idle = (q.size() == 0) || q[0].is_done;
      vectors++;
      if (q.size() == 0) begin
        ok = !reg_en && !rsp_done && req_ready;
        if (!ok) begin
          errors++;
          $display("FAIL R6 idle cycle: ready=%b en=%b done=%b, expected ready=1 en=0 done=0",
                   req_ready, reg_en, rsp_done);
        end
      end else begin
        e = q.pop_front();
        ok = (req_ready == idle);
        if (e.is_done)
          ok = ok && !reg_en && rsp_done && (rsp_rdata == e.data);
        else
          ok = ok && !rsp_done && (reg_en == e.en) &&
               (!e.en || ((reg_we == e.we) && (int'(reg_addr) == e.addr) &&
                          (!e.we || reg_wdata == e.data)));
        if (!ok) begin
          errors++;
          $display("FAIL %s (R5/R6 timing): ready=%b en=%b we=%b addr=%h wdata=%h done=%b rdata=%h; expected ready=%b en=%b we=%b addr=%h data=%h done=%b",
                   e.tag, req_ready, reg_en, reg_we, reg_addr, reg_wdata, rsp_done, rsp_rdata,
                   idle, e.en, e.we, e.addr, e.data, e.is_done);
        end
      end

      if (started && idle && sq.size() > 0) begin
        stim_t s;
        s = sq.pop_front();
        req_valid = 1'b1; req_sel = s.sel; req_write = s.wr; req_ext = s.ext;
        req_wdata = s.wd; req_ext_data = s.xd;
        perturb_arm = s.perturb; pester_arm = s.pester;
        plan(s);
      end else if (!idle && pester_arm) begin
        // R6: request raised while busy must not start anything
        req_valid = 1'b1; req_sel = 5'b00000; req_write = 1'b1; req_ext = 1'b1;
        req_wdata = 32'hBAD0_BAD0; req_ext_data = 32'hBAD1_BAD1;
      end else begin
        req_valid = 1'b0;
      end

      if (started && sq.size() == 0 && q.size() == 0) idle_run++;
      else idle_run = 0;
      if (idle_run >= 4) finished = 1;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cyc);
        finished = 1;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_ext = 1'b0; req_sel = '0;
    req_wdata = '0; req_ext_data = '0;
    repeat (3) begin
      @(negedge clk);
      vectors++;
      // R10: idle outputs while reset is held
      if (!(req_ready && !reg_en && !rsp_done)) begin
        errors++;
        $display("FAIL R10 reset: ready=%b en=%b done=%b, expected ready=1 en=0 done=0",
                 req_ready, reg_en, rsp_done);
      end
    end
    rst_n = 1'b1;

    add(5'b00000, 0, 0, 0, 0, 0, 0, "R1 read acc0");
    add(5'b00011, 0, 0, 0, 0, 0, 1, "R6 read acc3 with busy requests");
    add(5'b00001, 1, 0, 32'hCAFE_0001, 0, 0, 0, "R2 write acc1");
    add(5'b00010, 1, 1, 32'h1234_5678, 32'h0000_00A5, 0, 0, "R3 write acc2 with extension");
    add(5'b00010, 0, 0, 0, 0, 0, 0, "R5 readback acc2");
    add(5'b00001, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, "R3 extension flag ignored on read");
    add(5'b00011, 1, 0, 32'h0BAD_F00D, 0, 1, 0, "R4 restore despite status change");
    add(5'b11011, 0, 0, 0, 0, 0, 0, "R7 fp5 upper read");
    add(5'b11010, 1, 0, 32'h5555_AAAA, 0, 0, 0, "R7 fp5 lower write");
    add(5'b10001, 1, 1, 32'h7777_0000, 32'h1, 0, 0, "R7 fp0 upper write, ext ignored");
    add(5'b11010, 0, 0, 0, 0, 0, 0, "R7 fp5 lower readback");
    add(5'b01000, 0, 0, 0, 0, 0, 0, "R8 stack slot 0 read");
    add(5'b01001, 1, 0, 32'h2000_FFF0, 0, 0, 0, "R8 stack slot 1 write");
    add(5'b00110, 0, 0, 0, 0, 0, 0, "R8 extension 2 read");
    add(5'b00101, 1, 1, 32'h0000_0042, 32'h9, 0, 0, "R8 extension 1 write, flag ignored");
    add(5'b01010, 1, 0, 32'h0000_0050, 0, 0, 0, "R8 status direct write");
    add(5'b00000, 0, 0, 0, 0, 0, 0, "R4 read acc0 saves new status");
    add(5'b01011, 1, 0, 32'hFFFF_0000, 0, 0, 0, "R9 reserved write");
    add(5'b01101, 0, 0, 0, 0, 0, 1, "R9 reserved read");
    add(5'b00001, 0, 0, 0, 0, 0, 0, "R1 read acc1 after write");

    repeat (5) @(negedge clk);
    started = 1;
    wait (finished);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule